// File: doc/BRIEF.md
# Storage band lock gate

The band lock gate sits beside a storage DMA path and decides, for each read or write request, whether the access may proceed. It keeps a table of address bands. Entry 0 is a global range that stands for the whole address space. Entries 1 to NBANDS-1 are numbered bands, each with a start address and a size. Every entry carries its own read-lock enable, write-lock enable and locked flag. Firmware sets up the table through a command port. The data path presents an address, a length and a direction, and one cycle later it receives a grant or a deny.

A lock blocks only the direction whose enable is set. Address space that no configured band covers falls back to the global range. With the global enables clear, that space is plain unprotected storage and every access to it is granted. A separate query port reports the lock flags of any entry, so the surrounding logic can read back the lock state. On reset, nothing in the table is kept. Every entry comes back locked, with both enables clear and with zero start and size.

Top module: `band_lock_gate`

## Requirements
- R1: Commands act on entry `cmd_band` when `cmd_valid` is high. Each `cmd_op` code has one effect:
  - 0 writes start and size. This op is ignored for entry 0.
  - 1 writes the read and write lock enables.
  - 2 writes the locked flag.
  - 3 disables the entry.
  A command to an entry index of NBANDS or higher changes nothing.
- R2: After reset every entry is locked, both of its enables are clear, and its start and size are zero.
- R3: A numbered band covers the addresses from start to start+size-1. A band whose size is zero covers nothing.
- R4: An access touches the addresses from addr to addr+max(len,1)-1, computed one bit wider than the address so that it does not wrap. The access is denied if it touches any configured numbered band that is locked and has the lock enable set for the access direction (`req_write` 1 = write).
- R5: An access that does not lie wholly inside a single configured numbered band also needs the global entry. Such an access is denied when entry 0 is locked and has the enable set for its direction. With the global enables clear, an uncovered access is granted.
- R6: The disable command (op 3) returns that entry to the reset values given in R2.
- R7: `rsp_valid` is high exactly one cycle after `req_valid`, and `rsp_grant` is never high while `rsp_valid` is low.
- R8: A query returns `qry_ack` one cycle later, together with the entry's locked flag, read enable and write enable. For an index of NBANDS or higher, all three flags read as zero.
- R9: A request or a query in the same cycle as a command sees the table as it was before that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 range, 1 enables, 2 lock, 3 disable |
| cmd_band | input | $clog2(NBANDS+1) | Target entry, 0 is global |
| cmd_start | input | ADDR_W | Band start address |
| cmd_size | input | ADDR_W | Band size in address units |
| cmd_rle | input | 1 | Read-lock enable value |
| cmd_wle | input | 1 | Write-lock enable value |
| cmd_lock | input | 1 | Locked flag value |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | ADDR_W | Access start address |
| req_len | input | ADDR_W | Access length, 0 treated as 1 |
| req_write | input | 1 | 1 for write, 0 for read |
| rsp_valid | output | 1 | Decision valid |
| rsp_grant | output | 1 | 1 grant, 0 deny |
| qry_valid | input | 1 | Lock-state query strobe |
| qry_band | input | $clog2(NBANDS+1) | Queried entry |
| qry_ack | output | 1 | Query result valid |
| qry_locked | output | 1 | Locked flag of queried entry |
| qry_rle | output | 1 | Read-lock enable of queried entry |
| qry_wle | output | 1 | Write-lock enable of queried entry |

## Verification
A table update and an access decision can land in the same cycle. The same holds for a table update and a lock-state query. The bench provokes both by presenting a lock command together with a request and a query aimed at the band being changed. It judges the results against a bench model that was updated only after the expected values were taken. The response must reflect the old lock state, and a request in the following cycle must reflect the new one.

// File: rtl/band_lock_gate.sv
module band_lock_gate #(
  parameter int NBANDS = 192,
  parameter int ADDR_W = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  input  logic [1:0]                  cmd_op,
  input  logic [$clog2(NBANDS+1)-1:0] cmd_band,
  input  logic [ADDR_W-1:0]           cmd_start,
  input  logic [ADDR_W-1:0]           cmd_size,
  input  logic                        cmd_rle,
  input  logic                        cmd_wle,
  input  logic                        cmd_lock,
  input  logic                        req_valid,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [ADDR_W-1:0]           req_len,
  input  logic                        req_write,
  output logic                        rsp_valid,
  output logic                        rsp_grant,
  input  logic                        qry_valid,
  input  logic [$clog2(NBANDS+1)-1:0] qry_band,
  output logic                        qry_ack,
  output logic                        qry_locked,
  output logic                        qry_rle,
  output logic                        qry_wle
);
  localparam int IW = $clog2(NBANDS+1);
  localparam logic [IW-1:0] NB_I = IW'(NBANDS);

  logic [ADDR_W-1:0] b_start [NBANDS];
  logic [ADDR_W-1:0] b_size  [NBANDS];
  logic [NBANDS-1:0] b_rle, b_wle, b_lock;

  wire cmd_hit = cmd_valid && (cmd_band < NB_I);
  wire qry_in  = qry_band < NB_I;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBANDS; i++) begin
        b_start[i] <= '0;
        b_size[i]  <= '0;
      end
      b_rle  <= '0;
      b_wle  <= '0;
      b_lock <= '1;
    end else if (cmd_hit) begin
      case (cmd_op)
        2'd0: if (cmd_band != '0) begin
          b_start[cmd_band] <= cmd_start;
          b_size[cmd_band]  <= cmd_size;
        end
        2'd1: begin
          b_rle[cmd_band] <= cmd_rle;
          b_wle[cmd_band] <= cmd_wle;
        end
        2'd2: b_lock[cmd_band] <= cmd_lock;
        default: begin
          b_start[cmd_band] <= '0;
          b_size[cmd_band]  <= '0;
          b_rle[cmd_band]   <= 1'b0;
          b_wle[cmd_band]   <= 1'b0;
          b_lock[cmd_band]  <= 1'b1;
        end
      endcase
    end
  end

  wire [ADDR_W-1:0] len_m1 = (req_len == '0) ? '0 : req_len - 1'b1;
  wire [ADDR_W:0]   acc_lo = {1'b0, req_addr};
  wire [ADDR_W:0]   acc_hi = acc_lo + {1'b0, len_m1};

  logic [NBANDS-1:0] blk_vec, cont_vec;
  assign blk_vec[0]  = 1'b0;
  assign cont_vec[0] = 1'b0;

  for (genvar g = 1; g < NBANDS; g++) begin : g_band
    wire [ADDR_W:0] lo   = {1'b0, b_start[g]};
    wire [ADDR_W:0] hx   = lo + {1'b0, b_size[g]};
    wire            live = b_size[g] != '0;
    wire            dir  = req_write ? b_wle[g] : b_rle[g];
    assign blk_vec[g]  = live && (acc_lo < hx) && (acc_hi >= lo) && b_lock[g] && dir;
    assign cont_vec[g] = live && (acc_lo >= lo) && (acc_hi < hx);
  end

  wire glob_blk = !(|cont_vec) && b_lock[0] && (req_write ? b_wle[0] : b_rle[0]);
  wire deny     = (|blk_vec) || glob_blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_grant  <= 1'b0;
      qry_ack    <= 1'b0;
      qry_locked <= 1'b0;
      qry_rle    <= 1'b0;
      qry_wle    <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_grant  <= req_valid && !deny;
      qry_ack    <= qry_valid;
      qry_locked <= qry_in && b_lock[qry_band];
      qry_rle    <= qry_in && b_rle[qry_band];
      qry_wle    <= qry_in && b_wle[qry_band];
    end
  end
endmodule

// File: rtl/band_lock_gate_chk.sv
module band_lock_gate_chk #(
  parameter int NBANDS = 192
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        cmd_valid,
  input logic [1:0]                  cmd_op,
  input logic [$clog2(NBANDS+1)-1:0] cmd_band,
  input logic                        req_valid,
  input logic                        rsp_valid,
  input logic                        rsp_grant,
  input logic                        qry_valid,
  input logic [$clog2(NBANDS+1)-1:0] qry_band,
  input logic                        qry_ack,
  input logic                        qry_locked,
  input logic                        qry_rle,
  input logic                        qry_wle
);
  localparam int IW = $clog2(NBANDS+1);
  localparam logic [IW-1:0] NB_I = IW'(NBANDS);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst) req_valid |=> rsp_valid); // R7
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst) !req_valid |=> !rsp_valid); // R7
  AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst) !rsp_valid |-> !rsp_grant); // R7
  AST_QRY_ACK: assert property (@(posedge clk) disable iff (rst) qry_valid |=> qry_ack); // R8
  AST_QRY_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
    (qry_valid && qry_band >= NB_I) |=> (!qry_locked && !qry_rle && !qry_wle)); // R8
  AST_DISABLE_RESTORES: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd3 && cmd_band < NB_I) ##1
    (qry_valid && qry_band == $past(cmd_band) && !cmd_valid)
    |=> (qry_locked && !qry_rle && !qry_wle)); // R6
endmodule

bind band_lock_gate band_lock_gate_chk #(.NBANDS(NBANDS)) u_chk (.*);

// File: tb/sim_band_lock_gate.sv
module sim_band_lock_gate;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int AW = 6;
  localparam int IW = $clog2(NB+1);

  logic clk = 0, rst = 1;
  logic cmd_valid = 0; logic [1:0] cmd_op = 0; logic [IW-1:0] cmd_band = 0;
  logic [AW-1:0] cmd_start = 0, cmd_size = 0;
  logic cmd_rle = 0, cmd_wle = 0, cmd_lock = 0;
  logic req_valid = 0; logic [AW-1:0] req_addr = 0, req_len = 0; logic req_write = 0;
  logic rsp_valid, rsp_grant;
  logic qry_valid = 0; logic [IW-1:0] qry_band = 0;
  logic qry_ack, qry_locked, qry_rle, qry_wle;

  band_lock_gate #(.NBANDS(NB), .ADDR_W(AW)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  int m_start [8]; int m_size [8];
  bit m_rle [8]; bit m_wle [8]; bit m_lock [8];

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic bit exp_grant(int a, int l, bit w);
    int hi = a + ((l == 0) ? 0 : l - 1);
    bit blk = 0, cont = 0;
    for (int b = 1; b < NB; b++) begin
      if (m_size[b] != 0) begin
        int lo = m_start[b];
        int hx = m_start[b] + m_size[b];
        if (a < hx && hi >= lo && m_lock[b] && (w ? m_wle[b] : m_rle[b])) blk = 1;
        if (a >= lo && hi < hx) cont = 1;
      end
    end
    if (!cont && m_lock[0] && (w ? m_wle[0] : m_rle[0])) blk = 1;
    return !blk;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < 8; b++) begin
      m_start[b] = 0; m_size[b] = 0; m_rle[b] = 0; m_wle[b] = 0; m_lock[b] = 1;
    end
  endtask

  task automatic model_cmd(int op, int b, int s, int z, bit r, bit w, bit k);
    if (b >= NB) return;
    case (op)
      0: if (b != 0) begin m_start[b] = s; m_size[b] = z; end
      1: begin m_rle[b] = r; m_wle[b] = w; end
      2: m_lock[b] = k;
      default: begin m_start[b] = 0; m_size[b] = 0; m_rle[b] = 0; m_wle[b] = 0; m_lock[b] = 1; end
    endcase
  endtask

  task automatic set_cmd(int op, int b, int s, int z, bit r, bit w, bit k);
    cmd_valid = 1; cmd_op = 2'(op); cmd_band = IW'(b);
    cmd_start = AW'(s); cmd_size = AW'(z); cmd_rle = r; cmd_wle = w; cmd_lock = k;
  endtask

  task automatic do_cmd(int op, int b, int s, int z, bit r, bit w, bit k);
    @(negedge clk);
    set_cmd(op, b, s, z, r, w, k);
    model_cmd(op, b, s, z, r, w, k);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic req_chk(int a, int l, bit w, string tag);
    bit e;
    @(negedge clk);
    req_valid = 1; req_addr = AW'(a); req_len = AW'(l); req_write = w;
    e = exp_grant(a, l, w);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_grant !== e) begin
      failures++;
      $display("FAIL %s addr=%0d len=%0d wr=%0d actual valid=%b grant=%b expected grant=%b",
               tag, a, l, w, rsp_valid, rsp_grant, e);
    end
    req_valid = 0;
  endtask

  task automatic qry_chk(int b, string tag);
    bit el, er, ew;
    el = (b < NB) ? m_lock[b] : 0;
    er = (b < NB) ? m_rle[b] : 0;
    ew = (b < NB) ? m_wle[b] : 0;
    @(negedge clk);
    qry_valid = 1; qry_band = IW'(b);
    @(negedge clk);
    checks++;
    if (qry_ack !== 1'b1 || qry_locked !== el || qry_rle !== er || qry_wle !== ew) begin
      failures++;
      $display("FAIL %s band=%0d actual ack=%b l=%b r=%b w=%b expected l=%b r=%b w=%b",
               tag, b, qry_ack, qry_locked, qry_rle, qry_wle, el, er, ew);
    end
    qry_valid = 0;
  endtask

  task automatic sweep(string tag);
    int lens [4] = '{0, 1, 3, 9};
    for (int a = 0; a < (1 << AW); a++)
      for (int li = 0; li < 4; li++)
        for (int w = 0; w < 2; w++)
          req_chk(a, lens[li], w[0], tag);
  endtask

  initial begin
    bit e_old;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;

    // R2 reset state, R8 query path
    for (int b = 0; b < NB; b++) qry_chk(b, "R2 reset state");
    @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_grant !== 0) begin
      failures++;
      $display("FAIL R7 idle response actual %b%b expected 00", rsp_valid, rsp_grant);
    end
    // R5 everything unprotected after reset
    sweep("R5 reset sweep");

    // R3 R4 direction split, zero-size band ignored
    do_cmd(0, 1, 8, 8, 0, 0, 0);
    do_cmd(1, 1, 0, 0, 1, 0, 0);
    do_cmd(0, 2, 20, 6, 0, 0, 0);
    do_cmd(1, 2, 0, 0, 0, 1, 0);
    do_cmd(0, 3, 40, 0, 0, 0, 0);
    do_cmd(1, 3, 0, 0, 1, 1, 0);
    sweep("R4 R3 directional sweep");

    // R5 global fallback with band 1 unlocked
    do_cmd(1, 0, 0, 0, 1, 1, 0);
    do_cmd(2, 1, 0, 0, 0, 0, 0);
    do_cmd(0, 0, 33, 7, 0, 0, 0);
    sweep("R5 global sweep");

    // R4 overlapping bands, band reaching top of space
    do_cmd(2, 0, 0, 0, 0, 0, 0);
    do_cmd(0, 3, 12, 10, 0, 0, 0);
    do_cmd(2, 1, 0, 0, 0, 0, 1);
    do_cmd(0, 2, 60, 4, 0, 0, 0);
    do_cmd(1, 2, 0, 0, 1, 1, 0);
    sweep("R4 overlap sweep");

    // R6 disable restores reset values
    do_cmd(3, 3, 0, 0, 0, 0, 0);
    qry_chk(3, "R6 disabled band");
    sweep("R6 after disable");

    // R1 out-of-range command ignored, R8 out-of-range query zero
    do_cmd(1, 5, 0, 0, 1, 1, 0);
    do_cmd(2, 4, 0, 0, 0, 0, 0);
    qry_chk(5, "R8 out-of-range query");
    qry_chk(4, "R1 out-of-range ignored");
    for (int b = 0; b < NB; b++) qry_chk(b, "R1 table unchanged");
    do_cmd(0, 0, 5, 5, 0, 0, 0);
    sweep("R1 global range write ignored");

    // R9 same-cycle command and request/query
    @(negedge clk);
    set_cmd(2, 1, 0, 0, 0, 0, 0);
    req_valid = 1; req_addr = 10; req_len = 1; req_write = 0;
    qry_valid = 1; qry_band = 1;
    e_old = exp_grant(10, 1, 0);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 1 || rsp_grant !== e_old || e_old !== 0) begin
      failures++;
      $display("FAIL R9 same-cycle grant actual %b expected %b", rsp_grant, e_old);
    end
    checks++;
    if (qry_locked !== 1) begin
      failures++;
      $display("FAIL R9 same-cycle query actual %b expected 1", qry_locked);
    end
    cmd_valid = 0; req_valid = 0; qry_valid = 0;
    model_cmd(2, 1, 0, 0, 0, 0, 0);
    req_chk(10, 1, 0, "R9 next cycle sees update");
    qry_chk(1, "R9 query after update");

    // R2 reset again restores locked table
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    model_reset();
    for (int b = 0; b < NB; b++) qry_chk(b, "R2 second reset");
    sweep("R2 sweep after reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule